// File: doc/BRIEF.md
# PHY Test Port Write Sequencer

This block turns a configuration write into the pin toggling a PHY test port expects. One request carries an 8-bit register code, and a stream of one or more data bytes follows. The block drives four outputs: a test clock, a test enable, a test clear and an 8-bit test data bus. Enable high marks the code, and enable low marks the data. The code and the data are captured on opposite test-clock edges, so the order of the pin changes is fixed.

After reset the block pulses test clear once, before it accepts any request. After that it serves requests one at a time. Every pin change is held for a programmable number of system clocks, so the PHY's setup and hold times are met. A one-cycle done pulse closes each request.

Top module: `phy_tport_seq`

## Requirements
- R1: While reset is asserted, `tp_clk`, `tp_en` and `tp_din` are 0, `tp_clr` is 1, and `req_ready`, `dat_ready` and `done` are 0.
- R2: `tp_clr` falls on the H-th rising clock edge after reset is released and never rises again. `req_ready` is first 1 in the cycle in which `tp_clr` is 0. H is `hold_cycles`, with 0 treated as 1.
- R3: An accepted request produces these code steps in order: `tp_clk` to 1, `tp_din` to the code, `tp_en` to 1, `tp_clk` to 0, then `tp_en` to 0. `tp_en` only rises while `tp_clk` is 1.
- R4: Each data byte then produces these steps: `tp_clk` to 0, `tp_din` to the byte, then `tp_clk` to 1. `tp_din` never changes on the cycle in which `tp_clk` rises.
- R5: Each step, including the redundant clock-low step that opens the data phase, holds its pin values for exactly H system clocks.
- R6: A request carries any number of bytes, from 1 upward. The byte marked by `dat_last` is the final one.
- R7: `req_ready` is 1 only in idle. It falls on the edge that accepts a request and returns together with a one-cycle `done` pulse. That pulse comes H cycles after the last byte's clock rise.
- R8: `dat_ready` is 1 only in the last cycle of a data clock-low step. While no byte is offered, the block waits in that step and all test pins stay unchanged.
- R9: `tp_en` is 0 throughout the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_cycles | input | HOLD_W | Clocks per step (0 acts as 1), stable while busy |
| req_valid | input | 1 | Request offered |
| req_code | input | 8 | Register code of the request |
| req_ready | output | 1 | Block idle and able to accept |
| dat_valid | input | 1 | Data byte offered |
| dat_byte | input | 8 | Data byte |
| dat_last | input | 1 | Marks the final byte of the request |
| dat_ready | output | 1 | Data byte taken this cycle if valid |
| tp_clk | output | 1 | Test clock |
| tp_en | output | 1 | Test enable |
| tp_clr | output | 1 | Test clear |
| tp_din | output | 8 | Test data bus |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check several local rules on every cycle:
- test clear never comes back once released;
- enable rises only with the clock high, and stays low in the data phase;
- the data bus is steady when the clock rises;
- pins freeze while the block waits for a byte;
- ready drops on acceptance, and done is a single pulse seen with ready.

Only the bench's scenarios can show the complete ordering of the pin changes and their exact step lengths for several hold settings. The same goes for byte counts of one and many, a code equal to a data byte, a hold of zero acting as one, and the stretched step caused by a late byte.

// File: rtl/phy_tport_seq.sv
module phy_tport_seq #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic              req_valid,
  input  logic [7:0]        req_code,
  output logic              req_ready,
  input  logic              dat_valid,
  input  logic [7:0]        dat_byte,
  input  logic              dat_last,
  output logic              dat_ready,
  output logic              tp_clk,
  output logic              tp_en,
  output logic              tp_clr,
  output logic [7:0]        tp_din,
  output logic              done
);

  typedef enum logic [3:0] {
    ST_INIT, ST_IDLE, ST_C_CLKH, ST_C_DIN, ST_C_ENH, ST_C_CLKL, ST_C_ENL,
    ST_D_CLKL, ST_D_DIN, ST_D_CLKH
  } st_e;

  st_e               state;
  logic [HOLD_W-1:0] cnt;
  logic [7:0]        code_q;
  logic              last_q;

  wire [HOLD_W-1:0] h_last = (hold_cycles == '0) ? '0 : hold_cycles - 1'b1;
  wire tick    = (cnt == h_last);
  wire in_data = (state == ST_D_CLKL) || (state == ST_D_DIN) || (state == ST_D_CLKH);
  wire adv     = tick && ((state != ST_D_CLKL) || dat_valid);

  assign req_ready = (state == ST_IDLE);
  assign dat_ready = (state == ST_D_CLKL) && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (state == ST_IDLE || adv) begin
      cnt <= '0;
    end else if (!tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_INIT;
      tp_clk <= 1'b0;
      tp_en  <= 1'b0;
      tp_clr <= 1'b1;
      tp_din <= '0;
      done   <= 1'b0;
      code_q <= '0;
      last_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (req_valid) begin
          tp_clk <= 1'b1;
          code_q <= req_code;
          state  <= ST_C_CLKH;
        end
      end else if (adv) begin
        case (state)
          ST_INIT:   begin tp_clr <= 1'b0; state <= ST_IDLE;   end
          ST_C_CLKH: begin tp_din <= code_q; state <= ST_C_DIN; end
          ST_C_DIN:  begin tp_en <= 1'b1;  state <= ST_C_ENH;  end
          ST_C_ENH:  begin tp_clk <= 1'b0; state <= ST_C_CLKL; end
          ST_C_CLKL: begin tp_en <= 1'b0;  state <= ST_C_ENL;  end
          ST_C_ENL:  begin tp_clk <= 1'b0; state <= ST_D_CLKL; end
          ST_D_CLKL: begin
            tp_din <= dat_byte;
            last_q <= dat_last;
            state  <= ST_D_DIN;
          end
          ST_D_DIN:  begin tp_clk <= 1'b1; state <= ST_D_CLKH; end
          ST_D_CLKH: begin
            if (last_q) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              tp_clk <= 1'b0;
              state  <= ST_D_CLKL;
            end
          end
          default:   state <= ST_IDLE;
        endcase
      end
    end
  end

  a_r2_clr_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    !tp_clr |=> !tp_clr);
  a_r3_en_rises_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tp_en) |-> tp_clk);
  a_r4_din_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tp_clk) |-> $stable(tp_din));
  a_r9_en_low_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> !tp_en);
  a_r8_wait_freezes_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_ready && !dat_valid) |=> $stable({tp_clk, tp_en, tp_din}));
  a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r7_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/test_phy_tport_seq.sv
`timescale 1ns/1ps
module test_phy_tport_seq;
  localparam int HW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW-1:0] hold_cycles = 8'd3;
  logic req_valid = 1'b0, dat_valid = 1'b0, dat_last = 1'b0;
  logic [7:0] req_code = '0, dat_byte = '0;
  logic req_ready, dat_ready, tp_clk, tp_en, tp_clr, done;
  logic [7:0] tp_din;

  always #2 clk = ~clk;

  phy_tport_seq #(.HOLD_W(HW)) i_phy_tport_seq (
    .clk(clk), .rst_n(rst_n), .hold_cycles(hold_cycles),
    .req_valid(req_valid), .req_code(req_code), .req_ready(req_ready),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_last(dat_last),
    .dat_ready(dat_ready), .tp_clk(tp_clk), .tp_en(tp_en), .tp_clr(tp_clr),
    .tp_din(tp_din), .done(done));

  typedef struct { logic [11:0] v; string r; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  logic [7:0] pay [0:3];
  logic mc, me;
  logic [7:0] md;

  task automatic chk(input logic ok, input string req, input logic [11:0] act, input logic [11:0] exv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exv, $time);
    end
  endtask

  // vector layout: {ready, done, clk, en, din}
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      logic [11:0] a;
      e = sb.pop_front();
      a = {req_ready, done, tp_clk, tp_en, tp_din};
      chk(a === e.v, e.r, a, e.v);
    end
  end

  task automatic push_step(input int len, input string req);
    for (int k = 0; k < len; k++) begin
      exp_t e;
      e.v = {1'b0, 1'b0, mc, me, md};
      e.r = req;
      sb.push_back(e);
    end
  endtask

  task automatic send(input logic [7:0] code, input int n, input int h, input int stall);
    int hh;
    exp_t e;
    hh = (h == 0) ? 1 : h;
    @(negedge clk);
    hold_cycles = h[HW-1:0];
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_code  = code;
    dat_valid = (stall == 0);
    dat_byte  = pay[0];
    dat_last  = (n == 1);
    @(posedge clk);
    #1 req_valid = 1'b0;
    mc = 1'b1;               push_step(hh, "R3 code clk high");
    md = code;               push_step(hh, "R3 code on bus");
    me = 1'b1;               push_step(hh, "R3 enable high");
    mc = 1'b0;               push_step(hh, "R3 code clk low");
    me = 1'b0;               push_step(hh, "R3 enable low");
    for (int i = 0; i < n; i++) begin
      mc = 1'b0; push_step(hh + ((i == 0) ? stall : 0), "R8 R5 data clk low");
      md = pay[i]; push_step(hh, "R4 byte on bus");
      mc = 1'b1; push_step(hh, "R4 data clk high");
    end
    e.v = {1'b1, 1'b1, mc, me, md};
    e.r = "R7 done with ready";
    sb.push_back(e);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!dat_ready);
      if (i == 0 && stall > 0) begin
        repeat (stall) @(negedge clk);
        dat_valid = 1'b1;
      end
      @(posedge clk);
      #1;
      if (i + 1 < n) begin
        dat_byte = pay[i+1];
        dat_last = (i + 2 == n);
      end else begin
        dat_valid = 1'b0;
        dat_last  = 1'b0;
      end
    end
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    chk(req_ready && !done, "R7 idle after done", {req_ready, done, 10'd0}, {1'b1, 1'b0, 10'd0});
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    mc = 1'b0; me = 1'b0; md = '0;
    repeat (3) @(negedge clk);
    chk({tp_clk, tp_en, tp_din} == 10'd0 && tp_clr && !req_ready && !dat_ready && !done,
        "R1 reset state", {req_ready, done, tp_clk, tp_en, tp_din}, 12'd0);
    rst_n = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      if (k < 3) chk(tp_clr && !req_ready, "R2 clear held", {10'd0, tp_clr, req_ready}, 12'd2);
      else       chk(!tp_clr && req_ready, "R2 clear released", {10'd0, tp_clr, req_ready}, 12'd1);
    end
    // R6 single byte, hold 3
    pay[0] = 8'h3C;
    send(8'h5A, 1, 3, 0);
    // R6 several bytes, hold 1
    pay[0] = 8'hA5; pay[1] = 8'h00; pay[2] = 8'hFF;
    send(8'h12, 3, 1, 0);
    // R5 hold 0 acts as 1, code equal to byte
    pay[0] = 8'h44; pay[1] = 8'h81;
    send(8'h44, 2, 0, 0);
    // R8 late first byte stretches the clock-low step
    pay[0] = 8'h01; pay[1] = 8'h02;
    send(8'h80, 2, 2, 4);
    chk(!tp_clr, "R2 clear stays low", {11'd0, tp_clr}, 12'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule